// File: doc/BRIEF.md
# Transmit Buffer Request Tracker

This block keeps the request state of the transmit buffers of a CAN-style controller. Software asks for a buffer to be sent by writing a one into its bit of a request-set register. It withdraws a request by writing a one into the matching bit of a withdraw register. The block keeps a pending bitmap with one bit per buffer. Bit i always belongs to buffer i. It also keeps a sticky sent flag for each buffer. Both bitmaps can be read through a small word-wide register port.

On the engine side, the block offers the lowest-indexed pending buffer to a transmit engine. The engine claims that buffer with an accept strobe, and the offered index is then frozen until the engine signals completion or the block withdraws it. Completion arrives as a one-cycle pulse that carries a buffer index. If software withdraws the buffer that is being served, the block raises a one-cycle abort toward the engine. Message storage is not held here, so requesting a buffer that has already been sent simply sends its contents again.

Top module: `txreq_tracker`

## Requirements
- R1: Bit i of the pending word, read at byte address 0x10CC, is 1 exactly when buffer i is pending. A value of 2 therefore means that only buffer 1 is pending, and 3 means that buffers 0 and 1 are pending. The port `eng_pend` shows the same bitmap.
- R2: A write to 0x10D0 sets the pending bit of every buffer whose data bit is 1. Data bits that are 0 leave their buffers unchanged. A read of 0x10D0 returns 0.
- R3: A completion pulse (`eng_done`=1) whose `eng_done_idx` names a pending buffer clears that pending bit and sets the buffer's sent bit on the same clock edge. The sent bits are read at 0x10D8, with bit i belonging to buffer i.
- R4: A sent bit holds its value until its buffer is requested again. It clears on the same edge that sets the pending bit again. Requesting a buffer again makes it pending once more, and a buffer is never both pending and sent. If a request and a completion hit the same buffer in one cycle, the request wins.
- R5: A write to 0x10D4 clears the pending bit of every buffer whose data bit is 1. If a completion for that buffer arrives in the same cycle, the withdraw wins. A read of 0x10D4 returns 0.
- R6: When the block is not serving a buffer, `eng_req` is 1 exactly when any buffer is pending, and `eng_idx` is the lowest pending index. When no buffer is pending, `eng_idx` is 0.
- R7: When `eng_ack`=1 while `eng_req`=1, no buffer is being served and `eng_abort`=0, the offered buffer becomes the served buffer. While a buffer is served, `eng_req` stays 1 and `eng_idx` stays fixed. This lasts until that buffer completes or is withdrawn.
- R8: Withdrawing the served buffer, or withdrawing a buffer in the same cycle that it is accepted, drives `eng_abort` to 1 on the next cycle, for exactly one cycle. A withdrawn buffer never sets its sent bit.
- R9: A completion pulse for a buffer that is not pending changes neither bitmap.
- R10: Synchronous active-high reset clears both bitmaps and ends any service. After reset, `eng_req`, `eng_abort` and `reg_rdata` are 0.
- R11: A read strobe returns its data on `reg_rdata` one cycle later. The data reflects the state before that edge. Unmapped addresses read 0, and `reg_rdata` holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe |
| reg_addr | input | 16 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| eng_pend | output | 32 | Pending bitmap |
| eng_req | output | 1 | A buffer is offered or being served |
| eng_idx | output | 5 | Offered or served buffer index |
| eng_ack | input | 1 | Engine claims the offered buffer |
| eng_done | input | 1 | Completion pulse |
| eng_done_idx | input | 5 | Buffer index of the completion |
| eng_abort | output | 1 | One-cycle pulse: the served buffer was withdrawn |

## Verification
The assertions assume that the host performs at most one register access per cycle. They also assume that the engine reports completion only with a valid index, and that `eng_ack` is a level sampled only while the block offers a buffer. The bench engine claims a buffer at random only while the block offers one. It mostly completes the buffer it is serving, and now and then sends a completion with a random index, which may name a buffer that is not pending. The host model issues sparse request and withdraw masks, sometimes aimed at the served buffer, and reads every mapped address as well as one unmapped address.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam logic [11:0] OFF_PEND = 12'h0CC;
  localparam logic [11:0] OFF_ADD  = 12'h0D0;
  localparam logic [11:0] OFF_CAN  = 12'h0D4;
  localparam logic [11:0] OFF_OCC  = 12'h0D8;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_ADD,
    SEL_CAN,
    SEL_OCC
  } reg_sel_e;
endpackage

// File: rtl/txr_regif.sv
module txr_regif
  import txr_pkg::*;
#(
  parameter int NBUF = 32,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter logic [AW-1:0] BASE = 16'h1000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wen,
  input  logic            reg_ren,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  input  logic [NBUF-1:0] pend,
  input  logic [NBUF-1:0] occ,
  output logic [NBUF-1:0] add_mask,
  output logic [NBUF-1:0] can_mask,
  output logic [DW-1:0]   reg_rdata
);
  localparam logic [AW-1:0] A_PEND = BASE + AW'(OFF_PEND);
  localparam logic [AW-1:0] A_ADD  = BASE + AW'(OFF_ADD);
  localparam logic [AW-1:0] A_CAN  = BASE + AW'(OFF_CAN);
  localparam logic [AW-1:0] A_OCC  = BASE + AW'(OFF_OCC);

  reg_sel_e sel;
  logic [DW-1:0] rd_next;

  always_comb begin
    unique case (reg_addr)
      A_PEND:  sel = SEL_PEND;
      A_ADD:   sel = SEL_ADD;
      A_CAN:   sel = SEL_CAN;
      A_OCC:   sel = SEL_OCC;
      default: sel = SEL_NONE;
    endcase
  end

  always_comb begin
    add_mask = '0;
    can_mask = '0;
    if (reg_wen && sel == SEL_ADD) add_mask = reg_wdata[NBUF-1:0];
    if (reg_wen && sel == SEL_CAN) can_mask = reg_wdata[NBUF-1:0];
  end

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_PEND: rd_next[NBUF-1:0] = pend;
      SEL_OCC:  rd_next[NBUF-1:0] = occ;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          reg_rdata <= '0;
    else if (reg_ren) reg_rdata <= rd_next;
  end
endmodule

// File: rtl/txr_status.sv
module txr_status #(
  parameter int NBUF = 32,
  localparam int IW = $clog2(NBUF)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NBUF-1:0] add_mask,
  input  logic [NBUF-1:0] can_mask,
  input  logic            done_vld,
  input  logic [IW-1:0]   done_idx,
  output logic [NBUF-1:0] pend,
  output logic [NBUF-1:0] occ,
  output logic [NBUF-1:0] done_hit
);
  for (genvar i = 0; i < NBUF; i++) begin : g_buf
    logic req_hit;
    assign done_hit[i] = done_vld && (done_idx == IW'(i)) && pend[i] && !can_mask[i];
    assign req_hit     = add_mask[i] && !can_mask[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        pend[i] <= 1'b0;
        occ[i]  <= 1'b0;
      end else begin
        pend[i] <= req_hit | (pend[i] & ~can_mask[i] & ~done_hit[i]);
        occ[i]  <= req_hit ? 1'b0 : (occ[i] | done_hit[i]);
      end
    end
  end
endmodule

// File: rtl/txr_arbiter.sv
module txr_arbiter #(
  parameter int NBUF = 32,
  localparam int IW = $clog2(NBUF)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NBUF-1:0] pend,
  input  logic [NBUF-1:0] can_mask,
  input  logic [NBUF-1:0] done_hit,
  input  logic            eng_ack,
  output logic            eng_req,
  output logic [IW-1:0]   eng_idx,
  output logic            eng_abort,
  output logic            busy
);
  logic [IW-1:0] low;
  logic [IW-1:0] cur;
  logic          any;
  logic          take;

  always_comb begin
    low = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (pend[i]) low = IW'(i);
    end
  end

  assign any     = |pend;
  assign take    = eng_ack && !busy && !eng_abort && any;
  assign eng_req = busy | any;
  assign eng_idx = busy ? cur : low;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cur       <= '0;
      eng_abort <= 1'b0;
    end else if (busy) begin
      eng_abort <= can_mask[cur];
      if (can_mask[cur] || done_hit[cur]) busy <= 1'b0;
    end else if (take) begin
      cur       <= low;
      eng_abort <= can_mask[low];
      busy      <= !can_mask[low] && !done_hit[low];
    end else begin
      eng_abort <= 1'b0;
    end
  end
endmodule

// File: rtl/txreq_tracker.sv
module txreq_tracker #(
  parameter int NBUF = 32,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter logic [AW-1:0] BASE = 16'h1000,
  localparam int IW = $clog2(NBUF)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wen,
  input  logic            reg_ren,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic [NBUF-1:0] eng_pend,
  output logic            eng_req,
  output logic [IW-1:0]   eng_idx,
  input  logic            eng_ack,
  input  logic            eng_done,
  input  logic [IW-1:0]   eng_done_idx,
  output logic            eng_abort
);
  logic [NBUF-1:0] add_mask;
  logic [NBUF-1:0] can_mask;
  logic [NBUF-1:0] pend_q;
  logic [NBUF-1:0] occ_q;
  logic [NBUF-1:0] done_hit;
  logic            busy_q;

  txr_regif #(.NBUF(NBUF), .AW(AW), .DW(DW), .BASE(BASE)) u_regif (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_ren(reg_ren),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pend(pend_q), .occ(occ_q),
    .add_mask(add_mask), .can_mask(can_mask), .reg_rdata(reg_rdata)
  );

  txr_status #(.NBUF(NBUF)) u_status (
    .clk(clk), .rst(rst), .add_mask(add_mask), .can_mask(can_mask),
    .done_vld(eng_done), .done_idx(eng_done_idx),
    .pend(pend_q), .occ(occ_q), .done_hit(done_hit)
  );

  txr_arbiter #(.NBUF(NBUF)) u_arb (
    .clk(clk), .rst(rst), .pend(pend_q), .can_mask(can_mask),
    .done_hit(done_hit), .eng_ack(eng_ack), .eng_req(eng_req),
    .eng_idx(eng_idx), .eng_abort(eng_abort), .busy(busy_q)
  );

  assign eng_pend = pend_q;
endmodule

// File: rtl/txr_chk.sv
module txr_chk #(
  parameter int NBUF = 32,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter logic [AW-1:0] BASE = 16'h1000,
  localparam int IW = $clog2(NBUF)
) (
  input logic            clk,
  input logic            rst,
  input logic            reg_wen,
  input logic [AW-1:0]   reg_addr,
  input logic [DW-1:0]   reg_wdata,
  input logic [NBUF-1:0] eng_pend,
  input logic            eng_req,
  input logic [IW-1:0]   eng_idx,
  input logic            eng_done,
  input logic [IW-1:0]   eng_done_idx,
  input logic            eng_abort,
  input logic [NBUF-1:0] occ,
  input logic            busy
);
  localparam logic [AW-1:0] A_ADD = BASE + AW'(txr_pkg::OFF_ADD);
  localparam logic [AW-1:0] A_CAN = BASE + AW'(txr_pkg::OFF_CAN);

  AST_ADD_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
    (reg_wen && reg_addr == A_ADD) |=> ((eng_pend & $past(reg_wdata[NBUF-1:0])) == $past(reg_wdata[NBUF-1:0]))); // R2
  AST_DONE_SETS_OCC: assert property (@(posedge clk) disable iff (rst)
    (eng_done && eng_pend[eng_done_idx] && !reg_wen) |=> (occ[$past(eng_done_idx)] && !eng_pend[$past(eng_done_idx)])); // R3
  AST_PEND_OCC_EXCL: assert property (@(posedge clk) disable iff (rst)
    (occ & eng_pend) == '0); // R4
  AST_CANCEL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (reg_wen && reg_addr == A_CAN) |=> ((eng_pend & $past(reg_wdata[NBUF-1:0])) == '0)); // R5
  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!busy && eng_req) |-> (eng_pend[eng_idx] && ((eng_pend & ((NBUF'(1) << eng_idx) - NBUF'(1))) == '0))); // R6
  AST_IDX_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(eng_idx)); // R7
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (rst)
    eng_abort |=> !eng_abort); // R8
  AST_CANCEL_NO_OCC: assert property (@(posedge clk) disable iff (rst)
    (reg_wen && reg_addr == A_CAN) |=> ((occ & $past(reg_wdata[NBUF-1:0])) == ($past(occ) & $past(reg_wdata[NBUF-1:0])))); // R8
  AST_STRAY_DONE: assert property (@(posedge clk) disable iff (rst)
    (eng_done && !eng_pend[eng_done_idx] && !reg_wen) |=> ($stable(eng_pend) && $stable(occ))); // R9
endmodule

bind txreq_tracker txr_chk #(.NBUF(NBUF), .AW(AW), .DW(DW), .BASE(BASE)) u_chk (
  .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .eng_pend(eng_pend), .eng_req(eng_req), .eng_idx(eng_idx), .eng_done(eng_done),
  .eng_done_idx(eng_done_idx), .eng_abort(eng_abort), .occ(occ_q), .busy(busy_q)
);

// File: tb/tb_txreq_tracker.sv
`timescale 1ns/1ps
module tb_txreq_tracker;
  localparam int NB = 32;
  localparam logic [15:0] A_PEND = 16'h10CC, A_ADD = 16'h10D0, A_CAN = 16'h10D4,
                          A_OCC = 16'h10D8, A_BAD = 16'h1000;

  logic clk = 0, rst = 1;
  logic reg_wen = 0, reg_ren = 0;
  logic [15:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [NB-1:0] eng_pend;
  logic eng_req, eng_abort, eng_ack = 0, eng_done = 0;
  logic [4:0] eng_idx, eng_done_idx = 0;

  int total = 0, bad = 0;
  logic [31:0] mP = 0, mO = 0, mRd = 0;
  logic mBusy = 0, mAbort = 0, rdChk = 0;
  logic [4:0] mCur = 0;

  always #10 clk = ~clk;

  txreq_tracker dut (.*);

  function automatic logic [4:0] lowest(logic [31:0] v);
    logic [4:0] r = 0;
    for (int i = 31; i >= 0; i--) if (v[i]) r = 5'(i);
    return r;
  endfunction

  function automatic logic [31:0] rdexp(logic [15:0] a);
    if (a == A_PEND) return mP;
    if (a == A_OCC)  return mO;
    return 32'h0;
  endfunction

  task automatic chk(logic ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic [31:0] A, C, D;
    logic [4:0] lo;
    logic take;
    @(posedge clk);
    A = (reg_wen && reg_addr == A_ADD) ? reg_wdata : 32'h0;
    C = (reg_wen && reg_addr == A_CAN) ? reg_wdata : 32'h0;
    D = 0;
    if (eng_done && mP[eng_done_idx] && !C[eng_done_idx]) D[eng_done_idx] = 1'b1;
    lo = lowest(mP);
    rdChk = reg_ren;
    if (reg_ren) mRd = rdexp(reg_addr);
    take = eng_ack && !mBusy && !mAbort && (mP != 0);
    if (mBusy) begin
      mAbort = C[mCur];
      if (C[mCur] || D[mCur]) mBusy = 0;
    end else if (take) begin
      mCur = lo; mAbort = C[lo]; mBusy = !C[lo] && !D[lo];
    end else mAbort = 0;
    mO = ((mO | D) & ~(A & ~C));
    mP = (A & ~C) | (mP & ~C & ~D);
    @(negedge clk);
    chk(eng_pend == mP, "R1 R3 R5 pending bitmap", eng_pend, mP);
    chk(eng_req == (mBusy || mP != 0), "R6 R7 request", 32'(eng_req), 32'(mBusy || mP != 0));
    chk(eng_idx == (mBusy ? mCur : lowest(mP)), "R6 R7 index", 32'(eng_idx), 32'(mBusy ? mCur : lowest(mP)));
    chk(eng_abort == mAbort, "R8 abort", 32'(eng_abort), 32'(mAbort));
    if (rdChk) chk(reg_rdata == mRd, "R11 read data", reg_rdata, mRd);
    reg_wen = 0; reg_ren = 0; eng_ack = 0; eng_done = 0;
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    reg_wen = 1; reg_addr = a; reg_wdata = d; tick();
  endtask

  task automatic rd_expect(logic [15:0] a, logic [31:0] exp, string tag);
    reg_ren = 1; reg_addr = a; tick();
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk(!eng_req && !eng_abort && eng_pend == 0 && reg_rdata == 0, "R10 reset outputs", 32'(eng_pend), 0);
    rd_expect(A_PEND, 0, "R10 pending after reset");
    rd_expect(A_OCC, 0, "R10 sent after reset");
    wr(A_ADD, 32'h2);
    rd_expect(A_PEND, 32'h2, "R1 only buffer 1 pending");
    wr(A_ADD, 32'h0);
    rd_expect(A_PEND, 32'h2, "R2 zero write no effect");
    wr(A_ADD, 32'h1);
    rd_expect(A_PEND, 32'h3, "R1 buffers 0 and 1 pending");
    chk(eng_idx == 0, "R6 lowest index first", 32'(eng_idx), 0);
    rd_expect(A_ADD, 0, "R2 request reg reads 0");
    rd_expect(A_CAN, 0, "R5 withdraw reg reads 0");
    rd_expect(A_BAD, 0, "R11 unmapped reads 0");
    eng_ack = 1; tick();
    eng_done = 1; eng_done_idx = 0; tick();
    rd_expect(A_OCC, 32'h1, "R3 sent bit set on completion");
    chk(eng_idx == 1, "R6 next lowest", 32'(eng_idx), 1);
    eng_ack = 1; tick();
    wr(A_CAN, 32'h2);
    chk(eng_abort == 1, "R8 abort on served withdraw", 32'(eng_abort), 1);
    tick();
    chk(eng_abort == 0, "R8 abort one cycle", 32'(eng_abort), 0);
    rd_expect(A_OCC, 32'h1, "R8 withdrawn buffer not sent");
    eng_done = 1; eng_done_idx = 5; tick();
    rd_expect(A_OCC, 32'h1, "R9 stray completion ignored");
    wr(A_ADD, 32'h1);
    rd_expect(A_OCC, 32'h0, "R4 sent clears on new request");
    rd_expect(A_PEND, 32'h1, "R4 resend pending");
    eng_ack = 1; tick();
    reg_wen = 1; reg_addr = A_CAN; reg_wdata = 32'h1; eng_done = 1; eng_done_idx = 0; tick();
    chk(eng_abort == 1, "R8 withdraw beats completion abort", 32'(eng_abort), 1);
    rd_expect(A_OCC, 32'h0, "R5 withdraw beats completion");
    wr(A_ADD, 32'h8);
    eng_ack = 1; tick();
    wr(A_ADD, 32'h1);
    chk(eng_idx == 3, "R7 index held while served", 32'(eng_idx), 3);
    eng_done = 1; eng_done_idx = 3; tick();
    chk(eng_idx == 0, "R7 released after completion", 32'(eng_idx), 0);
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 3) begin
        reg_wen = 1; reg_addr = A_ADD;
        reg_wdata = (32'h1 << ($urandom % 32)) | (($urandom % 4 == 0) ? ($urandom & $urandom & $urandom) : 0);
      end else if (r == 3) begin
        reg_wen = 1; reg_addr = A_CAN;
        reg_wdata = (mBusy && $urandom % 2 == 0) ? (32'h1 << mCur) : (32'h1 << ($urandom % 32));
      end else if (r < 6) begin
        reg_ren = 1;
        case ($urandom % 5)
          0: reg_addr = A_PEND;
          1: reg_addr = A_ADD;
          2: reg_addr = A_CAN;
          3: reg_addr = A_OCC;
          default: reg_addr = A_BAD;
        endcase
      end
      if (mBusy && $urandom % 4 == 0) begin
        eng_done = 1; eng_done_idx = mCur;
      end else if ($urandom % 16 == 0) begin
        eng_done = 1; eng_done_idx = 5'($urandom % 32);
      end
      if (!mBusy && eng_req) eng_ack = 1'($urandom % 2);
      tick();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule